// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the serial clock of an I2C master from a fast system clock. A prescaler divides the system clock by DIV+1 to make a tick. The SCL low and high phases each last a programmed number of ticks. After every high phase the block waits a fixed 8-clock overhead plus a delay for the input glitch filter. It marks the falling and rising SCL edges with one-cycle pulses. It also pulses once inside the low phase, after the data hold interval, to tell the bus sequencer that SDA may now change.

Two timing sets are kept, one for standard/fast speed and one for high speed, and `hs_mode` selects between them. A fixed-ratio mode ignores the separate low and high counts: each phase lasts 8 ticks, so one SCL period is 16*(DIV+1) clocks. Settings are captured when each SCL period begins, so a change takes effect from the next period. The block also shows, as a combinational output, the period length that the current live settings would give.

The controller has four states: `ST_IDLE`, `ST_LOW`, `ST_HIGH` and `ST_SETTLE`. Its transitions are:
- IDLE to LOW when `run` is high.
- LOW to HIGH on the last low tick.
- HIGH to SETTLE on the last high tick, in normal mode.
- HIGH to LOW (if `run`) or to IDLE (if not), on the last high tick in fixed-ratio mode.
- SETTLE to LOW (if `run`) or to IDLE (if not), when the overhead count ends.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl` is 1 and `fall_stb`, `rise_stb` and `sda_upd_stb` are 0.
- R2: In normal mode, `rise_stb` comes (DIV+1)*(LOW+1) clocks after `fall_stb`.
- R3: In normal mode, consecutive `fall_stb` pulses are (DIV+1)*(LOW+HIGH+2) + 8 + K*FLT clocks apart. K is parameter FLT_MULT, 2 by default.
- R4: `sda_upd_stb` comes (HOLD+1)*(DIV+1) clocks after `fall_stb`, while `scl` is 0.
- R5: When `hs_mode` is 1 the `hs_*` set alone sets the timing; when it is 0 the `fs_*` set alone does.
- R6: When `fixed16` is 1, `rise_stb` comes 8*(DIV+1) clocks after `fall_stb` and the period is 16*(DIV+1) clocks. LOW, HIGH and FLT have no effect.
- R7: `period_cyc` equals the R3 or R6 formula for the live selected set and mode.
- R8: When `run` goes low, the current period completes, then `scl` stays 1 with no further `fall_stb`. When `run` is seen high in IDLE, `fall_stb` pulses one clock later.
- R9: Settings are captured when a period begins. Changing them mid-period alters only the following period.
- R10: `scl` falls only with `fall_stb` and rises only with `rise_stb`. The two pulses never coincide, and `sda_upd_stb` only occurs while `scl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| run | input | 1 | keep generating SCL periods |
| hs_mode | input | 1 | select high-speed timing set |
| fixed16 | input | 1 | fixed 16-tick period mode |
| flt_len | input | 3 | glitch-filter length FLT |
| fs_div | input | 8 | standard/fast prescaler DIV |
| fs_low | input | 8 | standard/fast low count |
| fs_high | input | 8 | standard/fast high count |
| fs_hold | input | 8 | standard/fast data hold count |
| hs_div | input | 8 | high-speed prescaler DIV |
| hs_low | input | 8 | high-speed low count |
| hs_high | input | 8 | high-speed high count |
| hs_hold | input | 8 | high-speed data hold count |
| scl | output | 1 | generated SCL level |
| fall_stb | output | 1 | pulse on SCL falling edge |
| rise_stb | output | 1 | pulse on SCL rising edge |
| sda_upd_stb | output | 1 | SDA may change now |
| period_cyc | output | 19 | computed SCL period in clocks |

## Verification
The assertions assume legal settings:
- LOW+HIGH is at least 2.
- HOLD is below the low count of the active mode (LOW in normal mode, 8 in fixed-ratio mode), so the SDA pulse always falls inside the low phase.
- Settings change only at period starts, or are captured safely by the block.

The stimulus keeps to these limits. It sweeps DIV 0 to 3, LOW 1 to 4, HIGH 1 to 3 and several filter lengths, with HOLD fixed at LOW-1. It writes new settings on the cycle after a `fall_stb`, and fills the unselected set with unrelated values so that selection errors show up in the measured intervals.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_SETTLE = 2'd3
    } scl_state_t;

    localparam int SETTLE_BASE = 8;
    localparam int FIXED_PHASE = 8;
endpackage

// File: rtl/i2c_scl_prescale.sv
module i2c_scl_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre;

    assign tick = !clear && (pre == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre <= '0;
        else if (clear || tick)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end
endmodule

// File: rtl/i2c_scl_period.sv
module i2c_scl_period #(
    parameter int DIV_W    = 8,
    parameter int CNT_W    = 8,
    parameter int FLT_W    = 3,
    parameter int FLT_MULT = 2,
    parameter int PER_W    = 19
) (
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] low,
    input  logic [CNT_W-1:0] high,
    input  logic [FLT_W-1:0] flt,
    input  logic             fixed16,
    output logic [PER_W-1:0] period
);
    logic [PER_W-1:0] ticks_sz;
    logic [PER_W-1:0] flt_term;
    logic [PER_W-1:0] base;

    assign ticks_sz = PER_W'(div) + 1'b1;

    generate
        if (FLT_MULT == 2) begin : g_flt_dbl
            assign flt_term = PER_W'(flt) << 1;
        end else begin : g_flt_sgl
            assign flt_term = PER_W'(flt);
        end
    endgenerate

    assign base = PER_W'(low) + PER_W'(high) + PER_W'(2);

    always_comb begin
        if (fixed16)
            period = ticks_sz << 4;
        else
            period = ticks_sz * base + PER_W'(i2c_scl_timer_pkg::SETTLE_BASE) + flt_term;
    end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_timer_pkg::*;
#(
    parameter  int DIV_W    = 8,
    parameter  int CNT_W    = 8,
    parameter  int FLT_W    = 3,
    parameter  int FLT_MULT = 2,
    localparam int PER_W    = DIV_W + CNT_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hs_mode,
    input  logic             fixed16,
    input  logic [FLT_W-1:0] flt_len,
    input  logic [DIV_W-1:0] fs_div,
    input  logic [CNT_W-1:0] fs_low,
    input  logic [CNT_W-1:0] fs_high,
    input  logic [CNT_W-1:0] fs_hold,
    input  logic [DIV_W-1:0] hs_div,
    input  logic [CNT_W-1:0] hs_low,
    input  logic [CNT_W-1:0] hs_high,
    input  logic [CNT_W-1:0] hs_hold,
    output logic             scl,
    output logic             fall_stb,
    output logic             rise_stb,
    output logic             sda_upd_stb,
    output logic [PER_W-1:0] period_cyc
);
    localparam int SET_W = FLT_W + 4;

    scl_state_t state, nxt;

    logic [DIV_W-1:0] sel_div;
    logic [CNT_W-1:0] sel_low, sel_high, sel_hold;

    logic [DIV_W-1:0] s_div;
    logic [CNT_W-1:0] s_low, s_high, s_hold;
    logic             s_fixed;
    logic [SET_W-1:0] s_settle;

    logic [CNT_W-1:0] ph_cnt;
    logic [SET_W-1:0] st_cnt;
    logic             tick, pre_clr, enter_low;
    logic [CNT_W-1:0] low_last, high_last;

    always_comb begin
        sel_div  = hs_mode ? hs_div  : fs_div;
        sel_low  = hs_mode ? hs_low  : fs_low;
        sel_high = hs_mode ? hs_high : fs_high;
        sel_hold = hs_mode ? hs_hold : fs_hold;
    end

    i2c_scl_period #(
        .DIV_W(DIV_W), .CNT_W(CNT_W), .FLT_W(FLT_W),
        .FLT_MULT(FLT_MULT), .PER_W(PER_W)
    ) u_period (
        .div(sel_div), .low(sel_low), .high(sel_high),
        .flt(flt_len), .fixed16(fixed16), .period(period_cyc)
    );

    assign pre_clr = (state != ST_LOW) && (state != ST_HIGH);

    i2c_scl_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(pre_clr), .div(s_div), .tick(tick)
    );

    assign low_last  = s_fixed ? CNT_W'(FIXED_PHASE - 1) : s_low;
    assign high_last = s_fixed ? CNT_W'(FIXED_PHASE - 1) : s_high;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (run) nxt = ST_LOW;
            ST_LOW:    if (tick && ph_cnt == low_last) nxt = ST_HIGH;
            ST_HIGH:   if (tick && ph_cnt == high_last)
                           nxt = s_fixed ? (run ? ST_LOW : ST_IDLE) : ST_SETTLE;
            ST_SETTLE: if (st_cnt == s_settle - 1'b1)
                           nxt = run ? ST_LOW : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign enter_low = (nxt == ST_LOW) && (state != ST_LOW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // phase and settle counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            st_cnt <= '0;
        end else begin
            if (state == ST_LOW || state == ST_HIGH) begin
                if (tick)
                    ph_cnt <= (nxt != state) ? '0 : ph_cnt + 1'b1;
            end else begin
                ph_cnt <= '0;
            end
            st_cnt <= (state == ST_SETTLE && nxt == ST_SETTLE) ? st_cnt + 1'b1 : '0;
        end
    end

    // capture settings at each period start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_div    <= '0;
            s_low    <= '0;
            s_high   <= '0;
            s_hold   <= '0;
            s_fixed  <= 1'b0;
            s_settle <= SET_W'(SETTLE_BASE);
        end else if (enter_low) begin
            s_div    <= sel_div;
            s_low    <= sel_low;
            s_high   <= sel_high;
            s_hold   <= sel_hold;
            s_fixed  <= fixed16;
            s_settle <= SET_W'(SETTLE_BASE) + SET_W'(FLT_MULT) * SET_W'(flt_len);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl         <= 1'b1;
            fall_stb    <= 1'b0;
            rise_stb    <= 1'b0;
            sda_upd_stb <= 1'b0;
        end else begin
            scl         <= (nxt != ST_LOW);
            fall_stb    <= enter_low;
            rise_stb    <= (nxt == ST_HIGH) && (state != ST_HIGH);
            sda_upd_stb <= (state == ST_LOW) && tick && (ph_cnt == s_hold);
        end
    end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
    parameter int PER_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fixed16,
    input logic             scl,
    input logic             fall_stb,
    input logic             rise_stb,
    input logic             sda_upd_stb,
    input logic [PER_W-1:0] period_cyc
);
    // R10: edges only with their pulses
    p_fall_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> fall_stb);
    p_rise_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl) |-> rise_stb);
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb}));
    // R4: SDA change only while SCL low
    p_sda_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd_stb |-> !scl);
    // R2: low phase persists at least one clock after fall
    p_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !scl);
    // R6: fixed mode period is a multiple of 16
    p_fixed_mult_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fixed16 |-> period_cyc[3:0] == 4'd0);
    // R7: normal period includes the 8-clock overhead
    p_period_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fixed16 |-> period_cyc >= PER_W'(10));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fixed16(fixed16), .scl(scl),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .sda_upd_stb(sda_upd_stb),
    .period_cyc(period_cyc)
);

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
    localparam int K = 2;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, hs_mode = 1'b0, fixed16 = 1'b0;
    logic [2:0] flt_len = '0;
    logic [7:0] fs_div = '0, fs_low = 8'd2, fs_high = 8'd1, fs_hold = 8'd1;
    logic [7:0] hs_div = '0, hs_low = 8'd2, hs_high = 8'd1, hs_hold = 8'd1;
    logic scl, fall_stb, rise_stb, sda_upd_stb;
    logic [18:0] period_cyc;

    int cyc = 0, checks = 0, fails = 0;
    int last_fall = 0, prev_exp = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_scl_timer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .hs_mode(hs_mode), .fixed16(fixed16),
        .flt_len(flt_len), .fs_div(fs_div), .fs_low(fs_low), .fs_high(fs_high),
        .fs_hold(fs_hold), .hs_div(hs_div), .hs_low(hs_low), .hs_high(hs_high),
        .hs_hold(hs_hold), .scl(scl), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .sda_upd_stb(sda_upd_stb), .period_cyc(period_cyc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ev(input int which, output int t);
        t = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ((which == 0 && fall_stb) || (which == 1 && rise_stb) ||
                (which == 2 && sda_upd_stb)) begin
                t = cyc;
                return;
            end
        end
    endtask

    function automatic int exp_per(bit fx, int d, int l, int h, int f);
        return fx ? 16 * (d + 1) : (d + 1) * (l + h + 2) + 8 + K * f;
    endfunction

    // called at the negedge right after a fall_stb
    task automatic run_cfg(bit hs, bit fx, int d, int l, int h, int hd, int f);
        int t, t0, ep, lowc;
        hs_mode = hs; fixed16 = fx; flt_len = 3'(f);
        if (hs) begin
            hs_div = 8'(d); hs_low = 8'(l); hs_high = 8'(h); hs_hold = 8'(hd);
            fs_div = 8'd6; fs_low = 8'd9; fs_high = 8'd7; fs_hold = 8'd0;
        end else begin
            fs_div = 8'(d); fs_low = 8'(l); fs_high = 8'(h); fs_hold = 8'(hd);
            hs_div = 8'd6; hs_low = 8'd9; hs_high = 8'd7; hs_hold = 8'd0;
        end
        ep = exp_per(fx, d, l, h, f);
        lowc = fx ? 8 * (d + 1) : (d + 1) * (l + 1);
        #1;
        check(int'(period_cyc) == ep, "R7 period_cyc", int'(period_cyc), ep);
        wait_ev(0, t);
        check(t - last_fall == prev_exp, "R9 old period kept", t - last_fall, prev_exp);
        t0 = t;
        wait_ev(2, t);
        check(t - t0 == (hd + 1) * (d + 1), "R4 sda hold", t - t0, (hd + 1) * (d + 1));
        wait_ev(1, t);
        check(t - t0 == lowc, fx ? "R6 fixed low" : (hs ? "R5 hs low" : "R2 low"), t - t0, lowc);
        wait_ev(0, t);
        check(t - t0 == ep, fx ? "R6 fixed period" : (hs ? "R5 hs period" : "R3 period"), t - t0, ep);
        last_fall = t;
        prev_exp = ep;
    endtask

    initial begin
        int t, tr, nf;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl == 1'b1, "R1 scl", int'(scl), 1);
        check({fall_stb, rise_stb, sda_upd_stb} == 3'b0, "R1 strobes",
              int'({fall_stb, rise_stb, sda_upd_stb}), 0);
        run = 1'b1;
        tr = cyc;
        wait_ev(0, t);
        check(t - tr == 1, "R8 start latency", t - tr, 1);
        last_fall = t;
        prev_exp = exp_per(0, 0, 2, 1, 0);

        for (int hs = 0; hs < 2; hs++)
            for (int d = 0; d < 4; d++)
                for (int l = 1; l < 5; l++)
                    for (int h = 1; h < 4; h++)
                        for (int fi = 0; fi < 3; fi++)
                            run_cfg(1'(hs), 1'b0, d, l, h, l - 1, fi == 0 ? 0 : (fi == 1 ? 5 : 7));
        for (int hs = 0; hs < 2; hs++)
            for (int d = 0; d < 4; d++)
                run_cfg(1'(hs), 1'b1, d, 2, 1, 3, 7);

        // R8: stop after current period
        run = 1'b0;
        nf = 0;
        for (int i = 0; i < prev_exp + 40; i++) begin
            @(negedge clk);
            if (fall_stb) nf++;
        end
        check(nf == 0, "R8 no fall when stopped", nf, 0);
        check(scl == 1'b1, "R8 scl idle high", int'(scl), 1);
        run = 1'b1;
        tr = cyc;
        wait_ev(0, t);
        check(t - tr == 1, "R8 restart latency", t - tr, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule